// File: doc/BRIEF.md
# Host Memory and Port Address Router

This block sits on the host side of a memory controller hub. Each host request carries an address, a space flag (memory or I/O port), a read/write flag and write data. The block decides which downstream port owns that address and raises one bit of a one-hot target select on the next clock. The possible targets are the legacy low region, system DRAM, three programmable windows (graphics aperture, interrupt-controller window, I/O aperture), and the downstream hub, which is the default owner.

The region boundaries come from configuration registers that are written through a plain register port:
- a top-of-low-memory boundary at 1 MB granularity;
- a top-of-populated-DRAM value in 16 MB units;
- a base, limit and enable for each window;
- a separate base, limit and enable for a graphics range in the I/O port space.

Requests that fall in no valid region have no target. For such a write, the data presented downstream is forced to zero and no port is selected. For such a read, the block flags the response and returns all-zero read data.

The request side uses a valid/ready handshake. `req_ready` is low while reset is asserted and high from the first clock after reset. After that the block never applies back-pressure, so a request is accepted in every cycle where `req_valid` is high. The response side has no ready: a response is presented for exactly one cycle and the consumer must take it.

Top module: `hostmap_router`

## Requirements

- R1: While reset is asserted, `rsp_valid`, `rsp_rd_zero`, `rsp_target` and `req_ready` are all zero. `req_ready` is high from the first clock edge after reset is released.
- R2: Each accepted request produces exactly one response, with `rsp_valid` high in the following cycle. `rsp_addr` and `rsp_write` echo the request. Back-to-back requests are each answered. A cycle with no accepted request gives `rsp_valid` low in the next cycle.
- R3: A memory request (`req_space`=0) whose address is below 1 MB selects the legacy target (`rsp_target` bit 0). This takes priority over every other region and window.
- R4: A memory address from 1 MB up to, but not including, the top-of-low-memory boundary selects DRAM (bit 1) when it is also below the populated top. The boundary register is index 0, with data bits 31:20 as the boundary in MB. The populated top is register index 1, with data bits 8:0 in 16 MB units.
- R5: A memory address at or above the top-of-low-memory boundary that hits no enabled window selects the hub (bit 5). After reset the boundary is zero, so every address at or above 1 MB goes to the hub.
- R6: Window k (k=0 graphics, bit 2; k=1 interrupt controller, bit 3; k=2 I/O aperture, bit 4) uses two registers:
  - base at register index 2+2k, data bits 31:20, with its enable in bit 0;
  - limit at index 3+2k, data bits 31:20.

  The window covers every address whose bits 31:20 lie between base and limit inclusive. A window whose enable is clear, or whose limit is below its base, never matches.
- R7: When windows overlap, the lowest k wins. Any address below the top-of-low-memory boundary is decided by the system-memory rule (R4/R8) and never by a window.
- R8: A memory address below the top-of-low-memory boundary but at or above the populated top is invalid.
- R9: For an invalid request, `rsp_target` is all zero. On a write, `rsp_wdata` is zero. On a read, `rsp_rd_zero` is high. `rsp_rdata` is always zero. On a valid write, `rsp_wdata` carries the request data.
- R10: In the I/O space (`req_space`=1), port addresses up to 0x10002 are valid and anything above is invalid. The port range is set by two registers:
  - base at register index 8, bits 15:0, with its enable in bit 31;
  - limit at index 9, bits 15:0.

  A port inside that inclusive range selects the graphics target (bit 2). Any other valid port selects the hub (bit 5).
- R11: A configuration write applies to requests accepted from the next cycle onward. A request accepted in the same cycle as the write is decoded with the old value.
- R12: `rsp_target` has at most one bit set, and it is all zero whenever `rsp_valid` is low.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_space | input | 1 | 0 = memory space, 1 = I/O port space |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_target | output | 6 | One-hot target: 0 legacy, 1 DRAM, 2 graphics, 3 interrupt window, 4 I/O aperture, 5 hub |
| rsp_write | output | 1 | Echo of the request write flag |
| rsp_addr | output | 32 | Echo of the request address |
| rsp_wdata | output | 32 | Write data to the target, zero when invalid |
| rsp_rd_zero | output | 1 | Read to invalid space, answered with zero data |
| rsp_rdata | output | 32 | Read data returned for invalid reads (all zero) |

## Verification

Addresses are placed on both sides of every boundary:
- 1 MB, the top of low memory and the populated top, which separate legacy, DRAM, the invalid hole and the hub;
- the first and last byte of each window, which shows the limit compare is inclusive;
- the 0x10002 port limit.

The windows are then made to overlap each other, the low region and DRAM, which tells the priority order apart from plain matching. Disabled windows and windows with an inverted range are probed to show they fall through to the hub. Finally, a configuration write is issued in the same cycle as a request, followed by the same request one cycle later, which separates old-value decoding from new-value decoding.

// File: rtl/hostmap_pkg.sv
package hostmap_pkg;

  typedef enum logic {
    SP_MEM = 1'b0,
    SP_IO  = 1'b1
  } space_e;

  // Target bit positions; windows follow TGT_WIN0, hub is the last bit.
  localparam int unsigned TGT_LEGACY = 0;
  localparam int unsigned TGT_DRAM   = 1;
  localparam int unsigned TGT_WIN0   = 2;

  // Configuration register indices; window k uses CFG_WIN0+2k and CFG_WIN0+2k+1.
  localparam int unsigned CFG_TOLM = 0;
  localparam int unsigned CFG_POP  = 1;
  localparam int unsigned CFG_WIN0 = 2;

  function automatic int unsigned cfg_io_index(input int unsigned nwin);
    return CFG_WIN0 + 2 * nwin;
  endfunction

endpackage

// File: rtl/hm_cfg_regs.sv
module hm_cfg_regs
  import hostmap_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned POP_W  = 9,
  parameter int unsigned IO_AW  = 16,
  parameter int unsigned NWIN   = 3,
  parameter int unsigned CFG_AW = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [DATA_W-1:0]            cfg_wdata,
  output logic [PAGE_W-1:0]            tolm_pg,
  output logic [POP_W-1:0]             pop_units,
  output logic [NWIN-1:0][PAGE_W-1:0]  win_base,
  output logic [NWIN-1:0][PAGE_W-1:0]  win_limit,
  output logic [NWIN-1:0]              win_en,
  output logic [IO_AW-1:0]             io_base,
  output logic [IO_AW-1:0]             io_limit,
  output logic                         io_en
);

  localparam int unsigned IO_IDX = cfg_io_index(NWIN);

  logic [PAGE_W-1:0] page_field;
  logic              unused_wdata;

  assign page_field   = cfg_wdata[DATA_W-1 -: PAGE_W];
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tolm_pg   <= '0;
      pop_units <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(CFG_TOLM)) tolm_pg   <= page_field;
      if (cfg_addr == CFG_AW'(CFG_POP))  pop_units <= cfg_wdata[POP_W-1:0];
    end
  end

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    logic [PAGE_W-1:0] base_q;
    logic [PAGE_W-1:0] limit_q;
    logic              en_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        limit_q <= '0;
        en_q    <= 1'b0;
      end else if (cfg_we) begin
        if (cfg_addr == CFG_AW'(CFG_WIN0 + 2 * k)) begin
          base_q <= page_field;
          en_q   <= cfg_wdata[0];
        end
        if (cfg_addr == CFG_AW'(CFG_WIN0 + 2 * k + 1)) limit_q <= page_field;
      end
    end

    assign win_base[k]  = base_q;
    assign win_limit[k] = limit_q;
    assign win_en[k]    = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_base  <= '0;
      io_limit <= '0;
      io_en    <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(IO_IDX)) begin
        io_base <= cfg_wdata[IO_AW-1:0];
        io_en   <= cfg_wdata[DATA_W-1];
      end
      if (cfg_addr == CFG_AW'(IO_IDX + 1)) io_limit <= cfg_wdata[IO_AW-1:0];
    end
  end

endmodule

// File: rtl/hm_win_cmp.sv
module hm_win_cmp #(
  parameter int unsigned PAGE_W = 12
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] base,
  input  logic [PAGE_W-1:0] limit,
  input  logic              en,
  output logic              hit
);

  // An inverted range (limit < base) can never satisfy both compares.
  always_comb begin
    hit = en && (page >= base) && (page <= limit);
  end

endmodule

// File: rtl/hm_io_decode.sv
module hm_io_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IO_AW  = 16,
  parameter int unsigned IO_TOP = 32'h0001_0002
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_AW-1:0]  base,
  input  logic [IO_AW-1:0]  limit,
  input  logic              en,
  output logic              io_ok,
  output logic              io_win_hit
);

  logic low_port;

  always_comb begin
    io_ok      = addr <= ADDR_W'(IO_TOP);
    low_port   = addr[ADDR_W-1:IO_AW] == '0;
    io_win_hit = io_ok && low_port && en &&
                 (addr[IO_AW-1:0] >= base) && (addr[IO_AW-1:0] <= limit);
  end

endmodule

// File: rtl/hm_tgt_select.sv
module hm_tgt_select
  import hostmap_pkg::*;
#(
  parameter int unsigned NWIN = 3,
  parameter int unsigned NTGT = NWIN + 3
) (
  input  logic            is_io,
  input  logic            legacy,
  input  logic            below_tolm,
  input  logic            populated,
  input  logic [NWIN-1:0] win_hit,
  input  logic            io_ok,
  input  logic            io_win_hit,
  output logic [NTGT-1:0] tgt,
  output logic            invalid
);

  localparam int unsigned TGT_HUB = NTGT - 1;

  logic [NWIN-1:0] win_pick;
  logic            found;

  always_comb begin
    win_pick = '0;
    found    = 1'b0;
    for (int k = 0; k < NWIN; k++) begin
      if (win_hit[k] && !found) begin
        win_pick[k] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    tgt     = '0;
    invalid = 1'b0;
    if (is_io) begin
      if (!io_ok)          invalid = 1'b1;
      else if (io_win_hit) tgt[TGT_WIN0] = 1'b1;
      else                 tgt[TGT_HUB] = 1'b1;
    end else if (legacy) begin
      tgt[TGT_LEGACY] = 1'b1;
    end else if (below_tolm) begin
      if (populated) tgt[TGT_DRAM] = 1'b1;
      else           invalid = 1'b1;
    end else if (found) begin
      tgt[TGT_WIN0 +: NWIN] = win_pick;
    end else begin
      tgt[TGT_HUB] = 1'b1;
    end
  end

endmodule

// File: rtl/hostmap_router.sv
module hostmap_router
  import hostmap_pkg::*;
#(
  parameter  int unsigned ADDR_W    = 32,
  parameter  int unsigned DATA_W    = 32,
  parameter  int unsigned MB_SHIFT  = 20,
  parameter  int unsigned POP_SHIFT = 24,
  parameter  int unsigned IO_AW     = 16,
  parameter  int unsigned IO_TOP    = 32'h0001_0002,
  parameter  int unsigned NWIN      = 3,
  localparam int unsigned NTGT      = NWIN + 3,
  localparam int unsigned CFG_AW    = $clog2(CFG_WIN0 + 2 * NWIN + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [NTGT-1:0]   rsp_target,
  output logic              rsp_write,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_wdata,
  output logic              rsp_rd_zero,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int unsigned PAGE_W = ADDR_W - MB_SHIFT;
  localparam int unsigned POP_W  = ADDR_W - POP_SHIFT + 1;

  logic [PAGE_W-1:0]           tolm_pg;
  logic [POP_W-1:0]            pop_units;
  logic [NWIN-1:0][PAGE_W-1:0] win_base;
  logic [NWIN-1:0][PAGE_W-1:0] win_limit;
  logic [NWIN-1:0]             win_en;
  logic [IO_AW-1:0]            io_base;
  logic [IO_AW-1:0]            io_limit;
  logic                        io_en;

  logic [PAGE_W-1:0] req_page;
  logic [POP_W-1:0]  req_units;
  logic              is_legacy;
  logic              is_below_tolm;
  logic              is_populated;
  logic [NWIN-1:0]   win_hit;
  logic              io_ok;
  logic              io_win_hit;
  logic [NTGT-1:0]   tgt_d;
  logic              invalid_d;
  logic              accept;
  logic              ready_q;
  space_e            space;

  hm_cfg_regs #(
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W),
    .POP_W  (POP_W),
    .IO_AW  (IO_AW),
    .NWIN   (NWIN),
    .CFG_AW (CFG_AW)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .tolm_pg   (tolm_pg),
    .pop_units (pop_units),
    .win_base  (win_base),
    .win_limit (win_limit),
    .win_en    (win_en),
    .io_base   (io_base),
    .io_limit  (io_limit),
    .io_en     (io_en)
  );

  assign space         = space_e'(req_space);
  assign req_page      = req_addr[ADDR_W-1 -: PAGE_W];
  assign req_units     = {1'b0, req_addr[ADDR_W-1 -: POP_W-1]};
  assign is_legacy     = req_page == '0;
  assign is_below_tolm = req_page < tolm_pg;
  assign is_populated  = req_units < pop_units;

  for (genvar k = 0; k < NWIN; k++) begin : g_cmp
    hm_win_cmp #(.PAGE_W(PAGE_W)) u_win (
      .page  (req_page),
      .base  (win_base[k]),
      .limit (win_limit[k]),
      .en    (win_en[k]),
      .hit   (win_hit[k])
    );
  end

  hm_io_decode #(
    .ADDR_W (ADDR_W),
    .IO_AW  (IO_AW),
    .IO_TOP (IO_TOP)
  ) u_io (
    .addr       (req_addr),
    .base       (io_base),
    .limit      (io_limit),
    .en         (io_en),
    .io_ok      (io_ok),
    .io_win_hit (io_win_hit)
  );

  hm_tgt_select #(
    .NWIN (NWIN),
    .NTGT (NTGT)
  ) u_sel (
    .is_io      (space == SP_IO),
    .legacy     (is_legacy),
    .below_tolm (is_below_tolm),
    .populated  (is_populated),
    .win_hit    (win_hit),
    .io_ok      (io_ok),
    .io_win_hit (io_win_hit),
    .tgt        (tgt_d),
    .invalid    (invalid_d)
  );

  assign req_ready = ready_q;
  assign accept    = req_valid && ready_q;
  assign rsp_rdata = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_target  <= '0;
      rsp_write   <= 1'b0;
      rsp_addr    <= '0;
      rsp_wdata   <= '0;
      rsp_rd_zero <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid   <= accept;
      rsp_target  <= accept ? tgt_d : '0;
      rsp_write   <= req_write;
      rsp_addr    <= req_addr;
      rsp_wdata   <= (accept && req_write && !invalid_d) ? req_wdata : '0;
      rsp_rd_zero <= accept && !req_write && invalid_d;
    end
  end

endmodule

// File: rtl/hostmap_router_chk.sv
module hostmap_router_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MB_SHIFT = 20,
  parameter int unsigned IO_TOP   = 32'h0001_0002,
  parameter int unsigned NTGT     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_space,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [NTGT-1:0]   rsp_target,
  input logic              rsp_write,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [DATA_W-1:0] rsp_wdata,
  input logic              rsp_rd_zero
);

  localparam logic [ADDR_W-1:0] LEG_TOP = {{(ADDR_W-1){1'b0}}, 1'b1} << MB_SHIFT;

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R2
  addr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_addr == $past(req_addr) && rsp_write == $past(req_write)));

  // R12
  target_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_target));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_target == '0 && !rsp_rd_zero));

  // R9
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rd_zero |-> (rsp_valid && !rsp_write && rsp_target == '0));

  // R9
  drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target == '0) |-> rsp_wdata == '0);

  // R3
  legacy_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_space && req_addr < LEG_TOP) |=> rsp_target == NTGT'(1));

  // R10
  io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_space && req_addr > ADDR_W'(IO_TOP)) |=> rsp_target == '0);

endmodule

bind hostmap_router hostmap_router_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .MB_SHIFT (MB_SHIFT),
  .IO_TOP   (IO_TOP),
  .NTGT     (NTGT)
) u_chk (.*);

// File: tb/hostmap_router_tb_top.sv
`timescale 1ns/1ps
module hostmap_router_tb_top;

  localparam logic [5:0] T_LEG  = 6'b000001;
  localparam logic [5:0] T_DRAM = 6'b000010;
  localparam logic [5:0] T_GFX  = 6'b000100;
  localparam logic [5:0] T_APIC = 6'b001000;
  localparam logic [5:0] T_IOAP = 6'b010000;
  localparam logic [5:0] T_HUB  = 6'b100000;
  localparam logic [5:0] T_NONE = 6'b000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_space = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [5:0]  rsp_target;
  logic        rsp_write;
  logic [31:0] rsp_addr;
  logic [31:0] rsp_wdata;
  logic        rsp_rd_zero;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  hostmap_router dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_space   (req_space),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_target  (rsp_target),
    .rsp_write   (rsp_write),
    .rsp_addr    (rsp_addr),
    .rsp_wdata   (rsp_wdata),
    .rsp_rd_zero (rsp_rd_zero),
    .rsp_rdata   (rsp_rdata)
  );

  task automatic expect_eq(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_rsp(input string tag, input logic [31:0] a, input logic wr,
                           input logic [31:0] wd, input logic [5:0] exp_t, input logic exp_zero);
    expect_eq(tag, "valid",   64'(rsp_valid), 64'(1'b1));
    expect_eq(tag, "target",  64'(rsp_target), 64'(exp_t));
    expect_eq(tag, "rd_zero", 64'(rsp_rd_zero), 64'(exp_zero));
    expect_eq(tag, "wdata",   64'(rsp_wdata), 64'((wr && exp_t != T_NONE) ? wd : 32'h0));
    expect_eq(tag, "rdata",   64'(rsp_rdata), 64'h0);
    expect_eq(tag, "addr",    64'(rsp_addr), 64'(a));
    expect_eq(tag, "write",   64'(rsp_write), 64'(wr));
  endtask

  task automatic access(input string tag, input logic sp, input logic [31:0] a,
                        input logic wr, input logic [5:0] exp_t, input logic exp_zero);
    logic [31:0] wd;
    wd = a ^ 32'h5A5A_A5A5;
    @(negedge clk);
    req_valid = 1'b1; req_space = sp; req_addr = a; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, a, wr, wd, exp_t, exp_zero);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    expect_eq("R1", "valid in reset",  64'(rsp_valid), 64'h0);
    expect_eq("R1", "ready in reset",  64'(req_ready), 64'h0);
    expect_eq("R1", "target in reset", 64'(rsp_target), 64'h0);
    expect_eq("R1", "zero in reset",   64'(rsp_rd_zero), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R1", "ready after reset", 64'(req_ready), 64'h1);
    expect_eq("R2", "idle valid", 64'(rsp_valid), 64'h0);
  endtask

  task automatic t_defaults();
    access("R3 legacy low", 1'b0, 32'h0000_1000, 1'b0, T_LEG, 1'b0);
    access("R5 hub at 1MB default", 1'b0, 32'h0010_0000, 1'b0, T_HUB, 1'b0);
    access("R5 hub top default", 1'b0, 32'hFFFF_FFFC, 1'b1, T_HUB, 1'b0);
  endtask

  task automatic t_dram();
    cfg_wr(0, 32'h4000_0000);
    cfg_wr(1, 32'h0000_0040);
    access("R4 dram first", 1'b0, 32'h0010_0000, 1'b1, T_DRAM, 1'b0);
    access("R4 dram last", 1'b0, 32'h3FFF_FFFC, 1'b0, T_DRAM, 1'b0);
    access("R5 hub at tolm", 1'b0, 32'h4000_0000, 1'b0, T_HUB, 1'b0);
    access("R3 legacy last", 1'b0, 32'h000F_FFFF, 1'b1, T_LEG, 1'b0);
  endtask

  task automatic t_hole();
    cfg_wr(1, 32'h0000_0030);
    access("R4 dram below pop", 1'b0, 32'h2FFF_FFFC, 1'b0, T_DRAM, 1'b0);
    access("R8 R9 hole read", 1'b0, 32'h3000_0000, 1'b0, T_NONE, 1'b1);
    access("R8 R9 hole write", 1'b0, 32'h3000_0000, 1'b1, T_NONE, 1'b0);
  endtask

  task automatic t_windows();
    cfg_wr(2, 32'hE000_0001); cfg_wr(3, 32'hE7F0_0000);
    cfg_wr(4, 32'hFEC0_0001); cfg_wr(5, 32'hFEC0_0000);
    cfg_wr(6, 32'hD000_0001); cfg_wr(7, 32'hD0F0_0000);
    access("R6 gfx base", 1'b0, 32'hE000_0000, 1'b1, T_GFX, 1'b0);
    access("R6 gfx limit inclusive", 1'b0, 32'hE7FF_FFFC, 1'b0, T_GFX, 1'b0);
    access("R6 above gfx", 1'b0, 32'hE800_0000, 1'b0, T_HUB, 1'b0);
    access("R6 below gfx", 1'b0, 32'hDFFF_FFFC, 1'b0, T_HUB, 1'b0);
    access("R6 apic", 1'b0, 32'hFEC0_0010, 1'b0, T_APIC, 1'b0);
    access("R6 above apic", 1'b0, 32'hFED0_0000, 1'b0, T_HUB, 1'b0);
    access("R6 ioap", 1'b0, 32'hD010_0000, 1'b1, T_IOAP, 1'b0);
    access("R6 ioap last", 1'b0, 32'hD0FF_FFFC, 1'b0, T_IOAP, 1'b0);
  endtask

  task automatic t_priority();
    cfg_wr(4, 32'hE000_0001); cfg_wr(5, 32'hE000_0000);
    access("R7 gfx over apic", 1'b0, 32'hE000_0100, 1'b0, T_GFX, 1'b0);
    cfg_wr(6, 32'h2000_0001); cfg_wr(7, 32'h3FF0_0000);
    access("R7 dram over window", 1'b0, 32'h2000_0000, 1'b0, T_DRAM, 1'b0);
    access("R7 R8 hole over window", 1'b0, 32'h3800_0000, 1'b0, T_NONE, 1'b1);
    cfg_wr(2, 32'h0000_0001); cfg_wr(3, 32'h0000_0000);
    access("R7 legacy over window", 1'b0, 32'h0008_0000, 1'b0, T_LEG, 1'b0);
    cfg_wr(6, 32'hE000_0001); cfg_wr(7, 32'hE000_0000);
    cfg_wr(2, 32'hE000_0000);
    access("R6 R7 gfx off apic over ioap", 1'b0, 32'hE000_0100, 1'b0, T_APIC, 1'b0);
    cfg_wr(4, 32'hE000_0000);
    access("R6 apic off ioap", 1'b0, 32'hE000_0100, 1'b0, T_IOAP, 1'b0);
    cfg_wr(6, 32'hE100_0001);
    access("R6 inverted range", 1'b0, 32'hE000_0100, 1'b0, T_HUB, 1'b0);
    access("R6 inverted range mid", 1'b0, 32'hE080_0000, 1'b0, T_HUB, 1'b0);
  endtask

  task automatic t_io();
    cfg_wr(8, 32'h8000_1000); cfg_wr(9, 32'h0000_10FF);
    access("R10 io window", 1'b1, 32'h0000_1080, 1'b1, T_GFX, 1'b0);
    access("R10 io window limit", 1'b1, 32'h0000_10FF, 1'b0, T_GFX, 1'b0);
    access("R10 io above window", 1'b1, 32'h0000_1100, 1'b0, T_HUB, 1'b0);
    access("R10 io other", 1'b1, 32'h0000_0CF8, 1'b0, T_HUB, 1'b0);
    access("R10 io top port", 1'b1, 32'h0001_0002, 1'b1, T_HUB, 1'b0);
    access("R10 R9 io over read", 1'b1, 32'h0001_0003, 1'b0, T_NONE, 1'b1);
    access("R10 R9 io over write", 1'b1, 32'h0001_0003, 1'b1, T_NONE, 1'b0);
  endtask

  task automatic t_cfg_timing();
    cfg_wr(1, 32'h0000_0080);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'h8000_0000;
    req_valid = 1'b1; req_space = 1'b0; req_addr = 32'h5000_0000; req_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    check_rsp("R11 same cycle old", 32'h5000_0000, 1'b0, 32'h0, T_HUB, 1'b0);
    req_addr = 32'h5000_0004;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R11 R2 next cycle new", 32'h5000_0004, 1'b0, 32'h0, T_DRAM, 1'b0);
    @(negedge clk);
    expect_eq("R2", "idle after burst", 64'(rsp_valid), 64'h0);
    expect_eq("R12", "idle target", 64'(rsp_target), 64'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_defaults();
    t_dram();
    t_hole();
    t_windows();
    t_priority();
    t_io();
    t_cfg_timing();
    finish_run();
  end

endmodule